// File: doc/BRIEF.md
# Scanned Four-Digit Seven-Segment Driver

This block lights a four-position common-anode seven-segment display from four BCD values. The positions share one eight-line cathode bus and a single digit-to-segment decoder. A scan counter cycles through eight slots. In each even slot one anode is on and the matching digit is decoded onto the cathodes. In each odd slot all anodes are off, but the same digit stays selected. This blank gap gives slow anode transistors time to turn off before the next position lights, so no ghost image appears.

The scan rate comes from a single-cycle refresh strobe: the counter steps once per strobe. The digit inputs are plain levels that are sampled continuously, not a stream, so there is no handshake. A new value appears the next time its position is scanned. Both outputs are registered and change together.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is held, `anode_o` is 1111 and `seg_o` is 11111111, and scanning restarts at slot 0 (units position).
- R2: At most one bit of `anode_o` is low at any time.
- R3: In slot 2k (k = 0..3), `anode_o` has only bit k low: 1110 selects the units digit `digits_i[3:0]`, 1101 selects `digits_i[7:4]`, 1011 selects `digits_i[11:8]`, and 0111 selects the thousands digit `digits_i[15:12]`.
- R4: In slot 2k+1, `anode_o` is 1111 while `seg_o` still carries the decode of digit k.
- R5: Segment patterns are active low, with the decimal point in bit 7 and segment g down to segment a in bits 6..0. The codes are: 0=11000000, 1=11111001, 2=10100100, 3=10110000, 4=10011001, 5=10010010, 6=10000010, 7=11111000, 8=10000000, 9=10010000.
- R6: A digit value from 10 to 15 decodes to 11111111, with all segments dark.
- R7: The slot advances by one on each clock where `refresh_en_i` is high and holds otherwise. After slot 7 it wraps to slot 0.
- R8: Both outputs are registered together. The values seen after a clock edge are those of the slot and the digits present before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| digits_i | input | 16 | Four BCD digits, units in the low nibble |
| refresh_en_i | input | 1 | One-cycle strobe that advances the scan slot |
| anode_o | output | 4 | Active-low anode enables |
| seg_o | output | 8 | Active-low segment pattern, decimal point in bit 7 |

## Verification
The assertions assume `refresh_en_i` and `digits_i` are known after reset. They do not assume anything about the strobe spacing: it may be high on every cycle, sparse, or absent for long stretches. The stimulus changes the digits and the strobe on the falling edge only. It uses back-to-back strobes, spaced strobes and stretches with no strobe, and covers all sixteen nibble values so that codes 10 to 15 reach the decoder.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
  localparam int SEG_W = 8;

  // active-low pattern, bit 7 = decimal point, bits 6..0 = g..a
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [3:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'd0: p = 8'b1100_0000;
      4'd1: p = 8'b1111_1001;
      4'd2: p = 8'b1010_0100;
      4'd3: p = 8'b1011_0000;
      4'd4: p = 8'b1001_1001;
      4'd5: p = 8'b1001_0010;
      4'd6: p = 8'b1000_0010;
      4'd7: p = 8'b1111_1000;
      4'd8: p = 8'b1000_0000;
      4'd9: p = 8'b1001_0000;
      default: p = '1;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/scan_slot_counter.sv
module scan_slot_counter #(
  parameter int SLOTS  = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      slot_o <= '0;
    else if (step_i) slot_o <= (slot_o == LAST) ? '0 : slot_o + 1'b1;
  end

  // R7
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(slot_o));
  // R7
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && slot_o == LAST) |=> slot_o == '0);
endmodule

// File: rtl/digit_select.sv
module digit_select #(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_W    = 4,
  localparam int IDX_W     = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
  input  logic [IDX_W-1:0]              idx_i,
  output logic [DIGIT_W-1:0]            digit_o
);
  logic [DIGIT_W-1:0] lane [NUM_DIGITS];

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_lane
    assign lane[g] = digits_i[g*DIGIT_W +: DIGIT_W];
  end

  assign digit_o = lane[idx_i];
endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
  import seg_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DIGIT_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
  input  logic                          refresh_en_i,
  output logic [NUM_DIGITS-1:0]         anode_o,
  output logic [SEG_W-1:0]              seg_o
);
  localparam int SLOTS  = 2 * NUM_DIGITS;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [SLOT_W-1:0]     slot;
  logic [IDX_W-1:0]      idx;
  logic                  blank;
  logic [DIGIT_W-1:0]    cur_digit;
  logic [NUM_DIGITS-1:0] anode_d;
  logic [SEG_W-1:0]      seg_d;

  scan_slot_counter #(.SLOTS(SLOTS)) u_slot (
    .clk(clk), .rst_n(rst_n), .step_i(refresh_en_i), .slot_o(slot)
  );

  assign idx   = IDX_W'(slot >> 1);
  assign blank = slot[0];

  digit_select #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_sel (
    .digits_i(digits_i), .idx_i(idx), .digit_o(cur_digit)
  );

  always_comb begin
    anode_d = '1;
    if (!blank) anode_d[idx] = 1'b0;
    seg_d = bcd_to_seg(cur_digit[3:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      anode_o <= '1;
      seg_o   <= '1;
    end else begin
      anode_o <= anode_d;
      seg_o   <= seg_d;
    end
  end

  // R2
  one_anode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~anode_o) <= 1);
  // R4
  blank_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> anode_o == '1);
  // R6
  bad_digit_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_digit > DIGIT_W'(9)) |=> seg_o == '1);
  // R8
  anode_follows_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |=> !anode_o[$past(idx)]);
endmodule

// File: tb/seg_scan_driver_bench.sv
module seg_scan_driver_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] digits = '0;
  logic        refresh = 0;
  logic [3:0]  anode;
  logic [7:0]  seg;

  int compared = 0, mismatched = 0;
  int m_slot = 0;
  logic [11:0] exp_q [$];
  bit done = 0;

  always #4 clk = ~clk;

  seg_scan_driver u_seg_scan_driver (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .refresh_en_i(refresh),
    .anode_o(anode), .seg_o(seg)
  );

  function automatic logic [7:0] ref_seg(input logic [3:0] v);
    logic [7:0] t [10] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99,
                           8'h92, 8'h82, 8'hF8, 8'h80, 8'h90};
    return (v > 9) ? 8'hFF : t[v];
  endfunction

  // driver: applies inputs at negedge, predicts the post-edge outputs (R8)
  task automatic drive(input logic [15:0] d, input logic r);
    logic [3:0] an;
    logic [3:0] dig;
    @(negedge clk);
    digits  = d;
    refresh = r;
    dig = d[(m_slot/2)*4 +: 4];
    an  = 4'hF;
    if (m_slot % 2 == 0) an[m_slot/2] = 1'b0;   // R3 / R4
    exp_q.push_back({an, ref_seg(dig)});         // R5 / R6
    if (r) m_slot = (m_slot == 7) ? 0 : m_slot + 1; // R7
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [11:0] e;
        e = exp_q.pop_front();
        compared++;
        if (anode !== e[11:8]) begin
          mismatched++;
          $display("FAIL R3/R4/R7 anode got %b exp %b", anode, e[11:8]);
        end
        if (seg !== e[7:0]) begin
          mismatched++;
          $display("FAIL R5/R6/R8 seg got %b exp %b", seg, e[7:0]);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (anode !== 4'hF || seg !== 8'hFF) begin
      mismatched++;
      $display("FAIL R1 reset got %b/%b exp 1111/11111111", anode, seg);
    end
    rst_n = 1;
    m_slot = 0;
    for (int i = 0; i < 40; i++) drive(16'h4321, 1'b1);
    for (int i = 0; i < 60; i++) drive(16'h8765, (i % 3) == 0);
    for (int i = 0; i < 20; i++) drive(16'h0909, 1'b0);
    for (int i = 0; i < 48; i++) drive(16'hFEDC, 1'b1);
    for (int i = 0; i < 48; i++) drive(16'hBA98, i[0]);
    for (int n = 0; n < 16; n++)
      for (int i = 0; i < 8; i++) drive({4{n[3:0]}}, 1'b1);
    drive(16'h1234, 1'b0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule